// File: doc/BRIEF.md
# Host Port Cycle-Steal Controller

This block is the slave side of a host access port. An external host selects the port and pulses a read or write strobe, all active low. The block answers on an active-low acknowledge and moves one word between the host and internal memory. It carries the request into the core clock domain. It then asks the core for the next free memory slot at the top of the steal priority order. Once the core's current operation has finished, it performs the transfer in one stolen core cycle and signals completion to the host.

The controller runs on a single rising-edge clock whose period is half a core cycle. An internal phase bit marks where each core cycle starts. The core reports its state through four inputs: an end-of-operation pulse, idle mode, slow-idle mode with its divisor, and a hung bus grant. These inputs set how long the steal must wait, so the acknowledge latency is not fixed. Lower-priority steal sources, such as block transfers or serial buffering, get grants only when the host port is not claiming the slot.

Top module: `hpcs_ctrl`

## Requirements
- R1: After reset the outputs are at rest: `hack_n` low (ready), `steal_req` low, `mem_en` low and `hrdata` zero. With no host activity, `other_gnt` follows `other_req` under R7.
- R2: While the port is ready and armed, `hack_n` goes high with no clock edge once `hsel_n` is low together with `hrd_n` or `hwr_n` low. `hwr_n` low means a write and `hrd_n` low means a read.
- R3: The request passes through a two-stage synchronizer. `steal_req` then rises only on an edge that starts a core cycle. Counting the first clock edge after the strobes assert as edge 1, `steal_req` is first high after edge 3 or edge 4.
- R4: The steal waits for the core's current operation. Edges in the wait state are counted from 1. With `slow_idle` high and divisor n, the wait ends at edge 1+2n. Otherwise, with `idle_mode` high, it ends at edge 1. Otherwise it ends at the first edge that samples `cyc_end` high. `steal_req` and `mem_en` are never high together.
- R5: The transfer takes one stolen core cycle: `mem_en` is high for exactly two clock periods. During that time it presents the captured address and direction: `mem_we` is 1 for a write and 0 for a read.
- R6: `hack_n` stays high during the transfer and for one more clock period after `mem_en` falls. It is low from the following edge onward.
- R7: Steal grants use fixed priority. The host port ranks first and `other_req[0]` ranks above `other_req[1]`. While `steal_req` or `mem_en` is high, `other_gnt` is all zero. Otherwise `other_gnt` is one-hot on the lowest-index active bit of `other_req`, or zero.
- R8: While `bus_hung` is high the steal waits without limit: `mem_en` stays low and `steal_req` stays high. After it drops, the waiting rule of R4 applies from that edge.
- R9: After an access completes, strobes that are still held start nothing. `hack_n` stays low and no transfer occurs until `hsel_n` or the strobes have been seen released through the synchronizer.
- R10: A read loads `hrdata` with `mem_rdata` at the end of the stolen cycle. `hrdata` holds that word while the port is ready, and writes leave it unchanged.
- R11: A write takes `hwdata` and `haddr` at the edge that accepts the request. A later change on the host data pins does not alter `mem_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-core-cycle clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel_n | input | 1 | Host port select, active low |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| haddr | input | AW | Host word address |
| hwdata | input | DW | Host write data |
| hack_n | output | 1 | Acknowledge: low = ready, high = busy |
| hrdata | output | DW | Last word read for the host |
| idle_mode | input | 1 | Core is in idle |
| slow_idle | input | 1 | Core is in slow idle |
| slow_div | input | DIVW | Slow-idle divisor n |
| cyc_end | input | 1 | Core's current operation ends at this edge |
| bus_hung | input | 1 | Bus granted away and held by another master |
| other_req | input | NOTHER | Lower-priority steal requests |
| other_gnt | output | NOTHER | Grants to the lower-priority sources |
| steal_req | output | 1 | Host port asks the core for a stolen cycle |
| mem_en | output | 1 | Stolen memory cycle in progress |
| mem_we | output | 1 | Stolen cycle is a write |
| mem_addr | output | AW | Memory address for the stolen cycle |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |

## Verification
The bench sweeps the wait sources: end-of-operation pulses at several delays, idle, slow idle with divisor zero and non-zero, and a hung grant held for many cycles. Each sweep would expose a design that miscounts the half-cycle wait or lets the steal slip past a held bus. It also holds the strobes after completion. A design without re-arming would start a second, duplicate transfer there. It changes the host data pins while the steal is pending. A design that does not latch the word would write the wrong value. Other steal sources request alongside the host, so a broken priority order would show as a grant during the host's slot. Reads and writes are interleaved to check that `hrdata` keeps the last read word.

// File: rtl/hpcs_pkg.sv
// Package: shared state encoding for the host port cycle-steal controller.
// Assumes: one clock period equals half a core cycle.
package hpcs_pkg;

    typedef enum logic [2:0] {
        ST_RDY   = 3'd0,   // port ready, waiting for a synchronized request
        ST_ALIGN = 3'd1,   // request seen mid-cycle, wait for the cycle start
        ST_REQ   = 3'd2,   // steal requested, waiting for the core operation
        ST_ACC0  = 3'd3,   // first half of the stolen cycle
        ST_ACC1  = 3'd4,   // second half of the stolen cycle
        ST_REL   = 3'd5    // half cycle before the acknowledge returns
    } hp_state_t;

    // Number of clock periods in one stolen core cycle.
    localparam int unsigned STEAL_HALVES = 2;

endpackage

// File: rtl/hpcs_sync.sv
// Module: multi-stage synchronizer for one asynchronous level.
// Assumes: input is a level held for at least STAGES+1 clock periods.
module hpcs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/hpcs_prio_arb.sv
// Module: fixed-priority grant for steal sources; index 0 ranks highest.
// Assumes: requests are levels; grant is combinational and one-hot or zero.
module hpcs_prio_arb #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    logic [N:0] taken;

    assign taken[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_slot
            // Grant a slot only when no higher-ranked slot already took it.
            assign gnt[i]       = req[i] & ~taken[i];
            assign taken[i + 1] = taken[i] | req[i];
        end
    endgenerate

endmodule

// File: rtl/hpcs_wait_timer.sv
// Module: decides when the core's current operation has finished.
// Order of rules: hung bus, slow idle, idle, end-of-operation pulse.
// Assumes: mode inputs stay stable while a steal is waiting.
module hpcs_wait_timer #(
    parameter int unsigned DIVW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            active,
    input  logic            idle_mode,
    input  logic            slow_idle,
    input  logic [DIVW-1:0] slow_div,
    input  logic            cyc_end,
    input  logic            bus_hung,
    output logic            done
);

    localparam int unsigned CW = DIVW + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] slow_last;

    // Last count value of a slow-idle wait: 1 + 2n edges in total.
    assign slow_last = {slow_div, 1'b0};

    // Count waiting edges; a held bus freezes the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (active && !bus_hung) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Pick the finishing rule for the current core mode.
    always_comb begin
        done = 1'b0;
        if (active && !bus_hung) begin
            if (slow_idle) begin
                done = (cnt == slow_last);
            end else if (idle_mode) begin
                done = 1'b1;
            end else begin
                done = cyc_end;
            end
        end
    end

endmodule

// File: rtl/hpcs_ctrl.sv
// Module: host port cycle-steal controller (top).
// Syncs host strobes, aligns to a core cycle start, waits for the core
// operation, steals one core cycle for the transfer and drives the
// acknowledge. Assumes: host holds select and strobe until acknowledge
// returns low; one clock period is half a core cycle.
module hpcs_ctrl
    import hpcs_pkg::*;
#(
    parameter int unsigned AW          = 12,
    parameter int unsigned DW          = 16,
    parameter int unsigned DIVW        = 4,
    parameter int unsigned NOTHER      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel_n,
    input  logic              hrd_n,
    input  logic              hwr_n,
    input  logic [AW-1:0]     haddr,
    input  logic [DW-1:0]     hwdata,
    output logic              hack_n,
    output logic [DW-1:0]     hrdata,
    input  logic              idle_mode,
    input  logic              slow_idle,
    input  logic [DIVW-1:0]   slow_div,
    input  logic              cyc_end,
    input  logic              bus_hung,
    input  logic [NOTHER-1:0] other_req,
    output logic [NOTHER-1:0] other_gnt,
    output logic              steal_req,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata
);

    localparam int unsigned NSRC = NOTHER + 1;

    hp_state_t     state, state_nx;
    logic          req_raw;
    logic          req_s;
    logic          phase;
    logic          armed;
    logic          accept;
    logic          wait_done;
    logic          we_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          host_claim;
    logic [NSRC-1:0] arb_req;
    logic [NSRC-1:0] arb_gnt;

    assign req_raw = !hsel_n && (!hrd_n || !hwr_n);

    hpcs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_raw),
        .q     (req_s)
    );

    // Two-phase counter: phase 0 marks the first half of a core cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
        end else begin
            phase <= ~phase;
        end
    end

    assign accept = (state == ST_RDY) && req_s && armed;

    // Re-arm only after the released strobes have crossed the synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
        end else if (accept) begin
            armed <= 1'b0;
        end else if (state == ST_RDY && !req_s) begin
            armed <= 1'b1;
        end
    end

    hpcs_wait_timer #(.DIVW(DIVW)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (state != ST_REQ),
        .active    (state == ST_REQ),
        .idle_mode (idle_mode),
        .slow_idle (slow_idle),
        .slow_div  (slow_div),
        .cyc_end   (cyc_end),
        .bus_hung  (bus_hung),
        .done      (wait_done)
    );

    // Next-state logic for the steal sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RDY:   if (accept) state_nx = phase ? ST_REQ : ST_ALIGN;
            ST_ALIGN: state_nx = ST_REQ;
            ST_REQ:   if (wait_done) state_nx = ST_ACC0;
            ST_ACC0:  state_nx = ST_ACC1;
            ST_ACC1:  state_nx = ST_REL;
            ST_REL:   state_nx = ST_RDY;
            default:  state_nx = ST_RDY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RDY;
        end else begin
            state <= state_nx;
        end
    end

    // Latch address, direction and write data when the request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            we_q    <= !hwr_n;
            addr_q  <= haddr;
            wdata_q <= hwdata;
        end
    end

    // Capture read data at the end of the stolen cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (state == ST_ACC1 && !we_q) begin
            rdata_q <= mem_rdata;
        end
    end

    assign host_claim = (state == ST_REQ) || (state == ST_ACC0) || (state == ST_ACC1);
    assign arb_req    = {other_req, host_claim};

    hpcs_prio_arb #(.N(NSRC)) u_arb (
        .req (arb_req),
        .gnt (arb_gnt)
    );

    assign other_gnt = arb_gnt[NSRC-1:1];
    assign steal_req = (state == ST_REQ);
    assign mem_en    = (state == ST_ACC0) || (state == ST_ACC1);
    assign mem_we    = mem_en && we_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign hrdata    = rdata_q;
    assign hack_n    = (state != ST_RDY) || (armed && req_raw);

endmodule

// File: rtl/hpcs_ctrl_chk.sv
// Module: property checker for hpcs_ctrl, attached with bind.
// Assumes: sampled on the controller clock, disabled during reset.
module hpcs_ctrl_chk #(
    parameter int unsigned DW     = 16,
    parameter int unsigned NOTHER = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hack_n,
    input logic              steal_req,
    input logic              mem_en,
    input logic              bus_hung,
    input logic [NOTHER-1:0] other_gnt,
    input logic [DW-1:0]     hrdata
);

    assert_wait_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(steal_req && mem_en));

    assert_steal_second_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_en) |=> mem_en);

    assert_steal_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && $past(mem_en)) |=> !mem_en);

    assert_ack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> hack_n);

    assert_ack_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_en) |=> !hack_n);

    assert_gnt_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(other_gnt));

    assert_host_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (steal_req || mem_en) |-> (other_gnt == '0));

    assert_hung_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (steal_req && bus_hung) |=> !mem_en);

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mem_en) |-> $stable(hrdata));

endmodule

bind hpcs_ctrl hpcs_ctrl_chk #(.DW(DW), .NOTHER(NOTHER)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hack_n    (hack_n),
    .steal_req (steal_req),
    .mem_en    (mem_en),
    .bus_hung  (bus_hung),
    .other_gnt (other_gnt),
    .hrdata    (hrdata)
);

// File: tb/hpcs_ctrl_tb.sv
// Bench: vector table walked by one loop, then directed corner cases.
module hpcs_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int DIVW = 4;
    localparam int NOTHER = 2;

    logic              clk, rst_n;
    logic              hsel_n, hrd_n, hwr_n;
    logic [AW-1:0]     haddr;
    logic [DW-1:0]     hwdata;
    logic              hack_n;
    logic [DW-1:0]     hrdata;
    logic              idle_mode, slow_idle, cyc_end, bus_hung;
    logic [DIVW-1:0]   slow_div;
    logic [NOTHER-1:0] other_req, other_gnt;
    logic              steal_req, mem_en, mem_we;
    logic [AW-1:0]     mem_addr;
    logic [DW-1:0]     mem_wdata, mem_rdata;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] last_rd = '0;

    // mode: 0 = end-of-operation pulse, 1 = idle, 2 = slow idle
    typedef struct packed {
        logic          we;
        logic [11:0]   addr;
        logic [15:0]   data;
        logic [1:0]    mode;
        logic [3:0]    div;
        logic [3:0]    dly;
        logic [1:0]    oreq;
        logic [5:0]    hung;
        logic          hold;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 12'h010, 16'h1234, 2'd0, 4'd0, 4'd0, 2'b00, 6'd0,  1'b0},
        '{1'b0, 12'h010, 16'h0000, 2'd0, 4'd0, 4'd3, 2'b00, 6'd0,  1'b0},
        '{1'b0, 12'h2A5, 16'h0000, 2'd1, 4'd0, 4'd0, 2'b01, 6'd0,  1'b0},
        '{1'b1, 12'h2A5, 16'hBEEF, 2'd2, 4'd3, 4'd0, 2'b11, 6'd0,  1'b0},
        '{1'b0, 12'h0FF, 16'h0000, 2'd2, 4'd0, 4'd0, 2'b00, 6'd0,  1'b1},
        '{1'b1, 12'h7FF, 16'h0F0F, 2'd1, 4'd0, 4'd0, 2'b10, 6'd20, 1'b0},
        '{1'b0, 12'h400, 16'h0000, 2'd0, 4'd0, 4'd7, 2'b10, 6'd0,  1'b1},
        '{1'b0, 12'hFFF, 16'h0000, 2'd0, 4'd0, 4'd2, 2'b00, 6'd5,  1'b0}
    };

    hpcs_ctrl #(.AW(AW), .DW(DW), .DIVW(DIVW), .NOTHER(NOTHER)) u_dut (
        .clk(clk), .rst_n(rst_n), .hsel_n(hsel_n), .hrd_n(hrd_n), .hwr_n(hwr_n),
        .haddr(haddr), .hwdata(hwdata), .hack_n(hack_n), .hrdata(hrdata),
        .idle_mode(idle_mode), .slow_idle(slow_idle), .slow_div(slow_div),
        .cyc_end(cyc_end), .bus_hung(bus_hung), .other_req(other_req),
        .other_gnt(other_gnt), .steal_req(steal_req), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [DW-1:0] rd_fn(input logic [AW-1:0] a);
        return (DW'(a) * 16'd7) ^ 16'hA5C3;
    endfunction

    // Bench memory: a read returns a value computed from the address.
    always_comb mem_rdata = (mem_en && !mem_we) ? rd_fn(mem_addr) : '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int n;
        int len;
        other_req = v.oreq;
        idle_mode = (v.mode == 2'd1);
        slow_idle = (v.mode == 2'd2);
        slow_div  = v.div;
        bus_hung  = (v.hung != 0);
        haddr     = v.addr;
        hwdata    = v.data;
        @(negedge clk);
        hsel_n = 1'b0;
        if (v.we) hwr_n = 1'b0; else hrd_n = 1'b0;
        #1 chk(hack_n == 1'b1, "R2 ack busy on strobe", hack_n, 1);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!steal_req && n < 12);
        chk(n == 3 || n == 4, "R3 steal request latency", n, 3);
        hwdata = ~v.data;
        haddr  = ~v.addr;
        if (v.oreq != 0) chk(other_gnt == '0, "R7 host ranks first", other_gnt, 0);
        for (int j = 0; j < int'(v.hung); j++) begin
            @(negedge clk);
            chk(!mem_en && steal_req, "R8 hung bus holds steal", mem_en, 0);
        end
        bus_hung = 1'b0;
        len = (v.mode == 2'd0) ? int'(v.dly) + 1 :
              (v.mode == 2'd1) ? 1 : 1 + 2 * int'(v.div);
        for (int i = 1; i <= len; i++) begin
            cyc_end = (v.mode == 2'd0) && (i == len);
            @(negedge clk);
            cyc_end = 1'b0;
            if (i < len) chk(!mem_en, "R4 waits for core operation", mem_en, 0);
            else         chk(mem_en,  "R4 steal after wait ends", mem_en, 1);
        end
        chk(mem_addr == v.addr, "R11 address latched", mem_addr, v.addr);
        chk(mem_we == v.we, "R5 direction", mem_we, v.we);
        if (v.we) chk(mem_wdata == v.data, "R11 write data latched", mem_wdata, v.data);
        if (v.oreq != 0) chk(other_gnt == '0, "R7 no grant in stolen cycle", other_gnt, 0);
        @(negedge clk);
        chk(mem_en, "R5 second half of stolen cycle", mem_en, 1);
        @(negedge clk);
        chk(!mem_en && hack_n, "R6 release half busy", {mem_en, hack_n}, 2'b01);
        @(negedge clk);
        chk(!hack_n, "R6 ack ready", hack_n, 0);
        if (!v.we) last_rd = rd_fn(v.addr);
        chk(hrdata == last_rd, "R10 read data", hrdata, last_rd);
        if (v.hold) begin
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                chk(!hack_n && !steal_req && !mem_en, "R9 held strobes ignored",
                    {hack_n, steal_req, mem_en}, 0);
            end
        end
        hsel_n = 1'b1; hrd_n = 1'b1; hwr_n = 1'b1;
        other_req = '0;
        repeat (4) @(negedge clk);
        chk(hrdata == last_rd, "R10 read data held while ready", hrdata, last_rd);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 20000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; hsel_n = 1'b1; hrd_n = 1'b1; hwr_n = 1'b1;
        haddr = '0; hwdata = '0; idle_mode = 1'b0; slow_idle = 1'b0;
        slow_div = '0; cyc_end = 1'b0; bus_hung = 1'b0; other_req = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: rest state after reset
        chk(!hack_n && !steal_req && !mem_en, "R1 reset outputs",
            {hack_n, steal_req, mem_en}, 0);
        chk(hrdata == '0 && other_gnt == '0, "R1 reset data and grants", hrdata, 0);
        // R7: priority among other sources with the host idle
        other_req = 2'b11;
        #1 chk(other_gnt == 2'b01, "R7 lowest index wins", other_gnt, 2'b01);
        other_req = 2'b10;
        #1 chk(other_gnt == 2'b10, "R7 single request granted", other_gnt, 2'b10);
        other_req = '0;
        @(negedge clk);
        for (int v = 0; v < NVEC; v++) run_vec(VEC[v]);
        // R9: after release a new access is accepted again
        run_vec('{1'b0, 12'h123, 16'h0000, 2'd1, 4'd0, 4'd0, 2'b00, 6'd0, 1'b0});
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule